// File: doc/BRIEF.md
# Timed-Unlock Brown-Out Sleep Disable

This block holds a two-bit control register that lets software switch off a brown-out detector for one sleep period. The kill bit cannot be written directly. Software first opens a short unlock window with one write and then arms the kill bit with a second write inside that window. Once armed, the kill bit takes effect after a fixed delay, stays in effect for a short stretch, and then clears itself with no further write.

If the sleep controller asks to sleep while the kill bit is in effect, the block raises a detector-off output. That output stays high until a wakeup event arrives. A sleep request at any other time leaves the detector running.

The register port is a plain strobe with two data bits. It has no back-pressure, and every strobe is taken in the cycle it is presented. Sleep and wake are plain single-cycle control pulses.

Top module: `bod_sleep_off`

## Requirements
- R1: While reset is held and in the first cycle after it, `rd_kill`, `rd_unlock` and `det_off` are all 0.
- R2: A strobed write with `wr_kill`=1 and `wr_unlock`=1 opens the unlock window. `rd_unlock` reads 1 for UNLOCK_WIN cycles after that edge and then reads 0. A new opening write restarts the window.
- R3: A strobed write with `wr_kill`=1 and `wr_unlock`=0 at any of the UNLOCK_WIN edges that follow the opening write sets the kill bit and closes the window. From the next cycle `rd_kill`=1 and `rd_unlock`=0. This includes the last edge, UNLOCK_WIN cycles after the opening write.
- R4: Once the window has closed by expiry, a write with `wr_kill`=1 and `wr_unlock`=0 leaves `rd_kill` at 0.
- R5: A strobed write with both data bits 0 while the window is open closes the window at once. A following kill write is then ignored.
- R6: After it is set, the kill bit reads 1 for exactly ARM_DLY+LIVE_LEN cycles and then clears itself. A further accepted arming write restarts this count.
- R7: The kill bit is in effect only from ARM_DLY cycles after it was set, for LIVE_LEN cycles. A sleep request sampled at an edge k cycles after the set edge counts only when ARM_DLY < k <= ARM_DLY+LIVE_LEN.
- R8: A sleep request while the kill bit is in effect raises `det_off` from the next cycle. `det_off` then holds through later cycles, including after the kill bit clears, until a wake pulse.
- R9: A wake pulse while `det_off` is 1 drives it to 0 in the next cycle. This holds even when a sleep request arrives in the same cycle.
- R10: A sleep request while the kill bit is not in effect leaves `det_off` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | Register write strobe |
| wr_kill | input | 1 | Write data: kill bit |
| wr_unlock | input | 1 | Write data: unlock-permit bit |
| sleep_req | input | 1 | Sleep-entry pulse from the sleep controller |
| wake | input | 1 | Wakeup pulse |
| rd_kill | output | 1 | Readback of the kill bit |
| rd_unlock | output | 1 | Readback of the unlock-permit bit |
| det_off | output | 1 | Brown-out detector switch-off request |

## Verification
The bench builds the block with its default values: UNLOCK_WIN=4, ARM_DLY=3 and LIVE_LEN=3. These values make the last legal arming edge reachable, as well as the first rejected one, one edge past the window. They also put the sleep edges just before, at the start of, and just after the effective stretch within a few cycles of arming. A timestamp model in the bench predicts every readback, so restarts, aborts and the wake-over-sleep priority are all checked cycle by cycle.

// File: rtl/bod_sleep_pkg.sv
package bod_sleep_pkg;
  typedef struct packed {
    logic stb;
    logic kill;
    logic unlock;
  } reg_wr_t;

  function automatic logic is_open_cmd(reg_wr_t w);
    return w.stb && w.kill && w.unlock;
  endfunction

  function automatic logic is_arm_cmd(reg_wr_t w);
    return w.stb && w.kill && !w.unlock;
  endfunction

  function automatic logic is_abort_cmd(reg_wr_t w);
    return w.stb && !w.kill && !w.unlock;
  endfunction
endpackage

// File: rtl/bod_unlock_win.sv
module bod_unlock_win
  import bod_sleep_pkg::*;
#(
  parameter int UNLOCK_WIN = 4
) (
  input  logic    clk,
  input  logic    rst_n,
  input  reg_wr_t wr,
  output logic    open,
  output logic    accept
);
  localparam int CW = $clog2(UNLOCK_WIN + 1);
  localparam logic [CW-1:0] WIN_LOAD = CW'(UNLOCK_WIN);

  logic [CW-1:0] cnt_q;

  assign open   = (cnt_q != '0);
  assign accept = open && is_arm_cmd(wr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (is_open_cmd(wr)) begin
      cnt_q <= WIN_LOAD;
    end else if (accept || (open && is_abort_cmd(wr))) begin
      cnt_q <= '0;
    end else if (open) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= WIN_LOAD); // R2
  AST_ABORT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (open && is_abort_cmd(wr)) |=> !open); // R5
  AST_OPEN_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    is_open_cmd(wr) |=> open); // R2
endmodule

// File: rtl/bod_arm_timer.sv
module bod_arm_timer #(
  parameter int ARM_DLY  = 3,
  parameter int LIVE_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic kill_bit,
  output logic effective
);
  localparam int TOTAL = ARM_DLY + LIVE_LEN;
  localparam int AW = $clog2(TOTAL + 1);
  localparam logic [AW-1:0] AGE_LAST = AW'(TOTAL);
  localparam logic [AW-1:0] AGE_ARM  = AW'(ARM_DLY);

  logic [AW-1:0] age_q;

  assign kill_bit  = (age_q != '0);
  assign effective = (age_q > AGE_ARM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      age_q <= '0;
    end else if (arm) begin
      age_q <= AW'(1);
    end else if (age_q == AGE_LAST) begin
      age_q <= '0;
    end else if (age_q != '0) begin
      age_q <= age_q + 1'b1;
    end
  end

  AST_ARM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> kill_bit); // R3
  AST_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> !effective); // R7
  AST_EFF_IMPLIES_SET: assert property (@(posedge clk) disable iff (!rst_n)
    effective |-> kill_bit); // R7
  AST_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == AGE_LAST && !arm) |=> !kill_bit); // R6
endmodule

// File: rtl/bod_sleep_gate.sv
module bod_sleep_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic effective,
  input  logic sleep_req,
  input  logic wake,
  output logic det_off
);
  logic off_q;

  assign det_off = off_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_q <= 1'b0;
    end else if (off_q && wake) begin
      off_q <= 1'b0;
    end else if (sleep_req && effective) begin
      off_q <= 1'b1;
    end
  end

  AST_OFF_NEEDS_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(off_q) |-> $past(sleep_req && effective)); // R10
  AST_WAKE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (off_q && wake) |=> !off_q); // R9
  AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (off_q && !wake) |=> off_q); // R8
endmodule

// File: rtl/bod_sleep_off.sv
module bod_sleep_off
  import bod_sleep_pkg::*;
#(
  parameter int UNLOCK_WIN = 4,
  parameter int ARM_DLY    = 3,
  parameter int LIVE_LEN   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_stb,
  input  logic wr_kill,
  input  logic wr_unlock,
  input  logic sleep_req,
  input  logic wake,
  output logic rd_kill,
  output logic rd_unlock,
  output logic det_off
);
  reg_wr_t wr;
  logic    win_open;
  logic    arm;
  logic    eff;

  assign wr = '{stb: wr_stb, kill: wr_kill, unlock: wr_unlock};

  bod_unlock_win #(.UNLOCK_WIN(UNLOCK_WIN)) u_win (
    .clk(clk), .rst_n(rst_n), .wr(wr), .open(win_open), .accept(arm)
  );

  bod_arm_timer #(.ARM_DLY(ARM_DLY), .LIVE_LEN(LIVE_LEN)) u_timer (
    .clk(clk), .rst_n(rst_n), .arm(arm), .kill_bit(rd_kill), .effective(eff)
  );

  bod_sleep_gate u_gate (
    .clk(clk), .rst_n(rst_n), .effective(eff), .sleep_req(sleep_req),
    .wake(wake), .det_off(det_off)
  );

  assign rd_unlock = win_open;

  AST_ARM_CONSUMES: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && !is_open_cmd(wr)) |=> (rd_kill && !rd_unlock)); // R3
  AST_LOCKED_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_unlock && !rd_kill && wr_stb && wr_kill && !wr_unlock) |=> !rd_kill); // R4
endmodule

// File: tb/bod_sleep_off_bench.sv
module bod_sleep_off_bench;
  localparam int WIN = 4;
  localparam int ARM = 3;
  localparam int LIVE = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_stb = 1'b0, wr_kill = 1'b0, wr_unlock = 1'b0, sleep_req = 1'b0, wake = 1'b0;
  logic rd_kill, rd_unlock, det_off;

  always #2 clk = ~clk;

  bod_sleep_off #(.UNLOCK_WIN(WIN), .ARM_DLY(ARM), .LIVE_LEN(LIVE)) u_bod_sleep_off (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_kill(wr_kill), .wr_unlock(wr_unlock),
    .sleep_req(sleep_req), .wake(wake), .rd_kill(rd_kill), .rd_unlock(rd_unlock),
    .det_off(det_off)
  );

  typedef struct {
    logic  kill;
    logic  unl;
    logic  off;
    string tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0;
  int n_bad = 0;

  // timestamp model built from the requirements
  int cyc = 0;
  int first_at = -1;
  int set_at = -1;
  logic m_off = 1'b0;

  task automatic check(input logic k, u, o, input string tag);
    n_chk++;
    if (rd_kill !== k || rd_unlock !== u || det_off !== o) begin
      n_bad++;
      $display("FAIL %s: got kill=%b unlock=%b off=%b, expected kill=%b unlock=%b off=%b",
               tag, rd_kill, rd_unlock, det_off, k, u, o);
    end
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(e.kill, e.unl, e.off, e.tag);
    end
  end

  task automatic step(input logic s, k, u, sl, wk, input string tag);
    logic w_open, eff;
    exp_t e;
    @(negedge clk);
    wr_stb = s; wr_kill = k; wr_unlock = u; sleep_req = sl; wake = wk;
    w_open = (first_at >= 0) && (cyc - first_at <= WIN) && (cyc > first_at);
    eff = (set_at >= 0) && (cyc - set_at > ARM) && (cyc - set_at <= ARM + LIVE);
    if (m_off && wk) m_off = 1'b0;
    else if (sl && eff) m_off = 1'b1;
    if (s && k && u) first_at = cyc;
    else if (s && k && !u && w_open) begin set_at = cyc; first_at = -1; end
    else if (s && !k && !u && w_open) first_at = -1;
    e.kill = (set_at >= 0) && (cyc - set_at < ARM + LIVE);
    e.unl = (first_at >= 0) && (cyc - first_at < WIN);
    e.off = m_off;
    e.tag = tag;
    @(posedge clk);
    q.push_back(e);
    cyc++;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, tag);
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got hung run, expected completion");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(0, 0, 0, "R1 in reset");
    rst_n = 1'b1;
    idle(2, "R1");
    // open, arm on last legal edge, sleep one edge too early then on time
    step(1, 1, 1, 0, 0, "R2 open");
    idle(3, "R2 window");
    step(1, 1, 0, 0, 0, "R3 arm at last edge");
    idle(2, "R6 counting");
    step(0, 0, 0, 1, 0, "R7 sleep before effective");
    step(0, 0, 0, 1, 0, "R8 sleep while effective");
    idle(6, "R8 hold past self-clear R6");
    step(0, 0, 0, 0, 1, "R9 wake");
    idle(1, "R9");
    // expiry then late kill write
    step(1, 1, 1, 0, 0, "R2 open");
    idle(4, "R2 expiry");
    step(1, 1, 0, 0, 0, "R4 late kill ignored");
    idle(8, "R4");
    // abort
    step(1, 1, 1, 0, 0, "R2 open");
    step(1, 0, 0, 0, 0, "R5 abort");
    step(1, 1, 0, 0, 0, "R5 kill after abort");
    idle(7, "R5");
    // restart of window and of kill count; sleep after effective stretch
    step(1, 1, 1, 0, 0, "R2 open");
    idle(2, "R2");
    step(1, 1, 1, 0, 0, "R2 restart");
    idle(3, "R2 restarted window");
    step(1, 1, 0, 0, 0, "R3 arm");
    idle(2, "R6");
    step(1, 1, 1, 0, 0, "R2 reopen while kill set");
    step(1, 1, 0, 0, 0, "R6 rearm restarts count");
    idle(6, "R6");
    step(0, 0, 0, 1, 0, "R10 sleep after clear");
    idle(3, "R10");
    // sleep at the final effective edge, then wake together with sleep
    step(1, 1, 1, 0, 0, "R2 open");
    step(1, 1, 0, 0, 0, "R3 arm first edge");
    idle(5, "R7");
    step(0, 0, 0, 1, 0, "R7 sleep at last effective edge");
    step(0, 0, 0, 1, 1, "R9 wake beats sleep");
    idle(3, "R9");
    @(negedge clk);
    @(negedge clk);
    report();
  end
endmodule